// File: doc/BRIEF.md
# Register-Mapped 16x16 Multiply-Accumulate Unit

This block is a small peripheral that multiplies two 16-bit operands and folds the product into a 48-bit running total. A processor drives it over a simple register bus: one write strobe, one read strobe, a 4-bit word address and 16-bit data in each direction. Software picks the operating mode in a control word, loads the two operand words, and reads back the total in three 16-bit slices or the latest raw 32-bit product in two slices.

Outside square mode, the write that completes a fresh operand pair starts the operation. In square mode, every write to either operand squares the written value. The product, the total and a sticky overflow bit are all updated on the clock edge that accepts that write, so they can be read in the next cycle. Products can be unsigned or signed. The term can be negated. The total can be loaded with the term, have the term added, or have it subtracted. A self-clearing clear bit in the control word empties the total.

Top module: `mulacc_unit`

## Requirements
- R1: Word addresses: 0 mode/control, 1 operand X, 2 operand Y, 3 total bits 47..32, 4 total bits 31..16, 5 total bits 15..0, 8 product bits 31..16, 9 product bits 15..0. A read of any other address returns 0. While the read strobe is low, the read data is 0. Read data is combinational from the stored state.
- R2: After reset, every register reads as zero.
- R3: Outside square mode, an operation fires on an operand write when the other operand has been written since the last operation. Repeated writes to the same operand fire nothing. Firing forgets both operand flags.
- R4: Results of a firing write are readable in the next cycle. A read of the same address in the same cycle as a write returns the value held before that write.
- R5: Control bit 0 = 1 selects an unsigned product, and 0 selects a signed product. Addresses 8/9 hold the raw 32-bit product (two's complement when signed) of the latest operation, whatever the other mode bits are.
- R6: When control bit 1 (accumulate) is 0, the total is loaded with the product, widened to 48 bits (sign-extended when signed, zero-extended when unsigned). If control bit 3 (negate) is 1, the widened product is negated first.
- R7: When accumulate is 1, the widened (and possibly negated) term is added to the total. If control bit 2 (subtract) is also 1, the term is subtracted instead. The result wraps modulo 2^48.
- R8: When control bit 4 (square) is 1, every write to operand X or Y fires at once using the written value as both factors.
- R9: Control bit 7 is a sticky overflow flag. It sets when an accumulating operation leaves the 48-bit range: signed range in signed mode, 0..2^48-1 in unsigned mode. It stays set until a clear. Writes to bit 7 have no effect.
- R10: Writing control with bit 5 = 1 zeroes the total and the overflow flag, and stores bits 4..0 as the new mode. Bits 5 and 6 always read 0.
- R11: The three total slices can be written directly. Writes to addresses 8, 9 and to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe; read data is 0 while low |
| addr | input | 4 | Word address shared by reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed word |

## Verification
Two functions can land in one cycle. The first case is a read strobe on the very write that completes an operand pair: the read must show the old operand word while the product and total update at that edge. The bench drives both strobes together on an operand address and expects the pre-write value, then reads the total in the next cycle. The second case is a control write that clears the total and switches the mode at once. The bench checks that the cleared total and the new mode both take effect, and that the next operation follows the new mode starting from zero.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

  localparam int WORD_W  = 16;
  localparam int PROD_W  = 2 * WORD_W;
  localparam int ACC_W   = 48;
  localparam int EXT_W   = ACC_W + 2;
  localparam int NSLICE  = ACC_W / WORD_W;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_OPX     = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_OPY     = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_ACC_LO  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_PROD_HI = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_PROD_LO = 4'd9;

  localparam int CB_CLEAR = 5;
  localparam int CB_OVF   = 7;

  // mode word, packed so that bit 0 is unsig and bit 4 is square
  typedef struct packed {
    logic square;
    logic negate;
    logic subtract;
    logic accum;
    logic unsig;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic             ovf;
  } acc_step_t;

  // address of total slice s (slice 0 holds the low bits)
  function automatic logic [ADDR_W-1:0] slice_addr(input int s);
    return ADDR_W'(int'(ADR_ACC_LO) - s);
  endfunction

  // raw product, two's complement when signed
  function automatic logic [PROD_W-1:0] mul_raw(input logic [WORD_W-1:0] x,
                                                input logic [WORD_W-1:0] y,
                                                input logic unsig);
    logic [PROD_W-1:0]        u_p;
    logic signed [PROD_W-1:0] s_p;
    u_p = PROD_W'(x) * PROD_W'(y);
    s_p = PROD_W'($signed(x)) * PROD_W'($signed(y));
    return unsig ? u_p : PROD_W'(s_p);
  endfunction

  function automatic logic [EXT_W-1:0] widen_prod(input logic [PROD_W-1:0] p,
                                                  input logic sx);
    return sx ? {{(EXT_W-PROD_W){p[PROD_W-1]}}, p}
              : {{(EXT_W-PROD_W){1'b0}}, p};
  endfunction

  function automatic logic [EXT_W-1:0] widen_acc(input logic [ACC_W-1:0] a,
                                                 input logic sx);
    return sx ? {{(EXT_W-ACC_W){a[ACC_W-1]}}, a}
              : {{(EXT_W-ACC_W){1'b0}}, a};
  endfunction

  // true when the wide result is representable in ACC_W bits
  function automatic logic fits_total(input logic [EXT_W-1:0] s,
                                      input logic unsig);
    if (unsig) return s[EXT_W-1:ACC_W] == '0;
    return s[EXT_W-1:ACC_W-1] == {(EXT_W-ACC_W+1){s[ACC_W-1]}};
  endfunction

  function automatic acc_step_t acc_step(input logic [ACC_W-1:0]  acc,
                                         input logic [PROD_W-1:0] p,
                                         input mode_t             m);
    acc_step_t        r;
    logic [EXT_W-1:0] term;
    logic [EXT_W-1:0] base;
    logic [EXT_W-1:0] sum;
    term = widen_prod(p, !m.unsig);
    if (m.negate) term = -term;
    base = widen_acc(acc, !m.unsig);
    if (!m.accum) begin
      sum   = term;
      r.ovf = 1'b0;
    end else begin
      sum   = m.subtract ? (base - term) : (base + term);
      r.ovf = !fits_total(sum, m.unsig);
    end
    r.acc = sum[ACC_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/mulacc_trigger.sv
module mulacc_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_x,
  input  logic wr_y,
  input  logic square,
  output logic fire
);

  logic x_seen_q;
  logic y_seen_q;

  always_comb begin
    fire = 1'b0;
    if (wr_x || wr_y) begin
      if (square)                fire = 1'b1;
      else if (wr_x && y_seen_q) fire = 1'b1;
      else if (wr_y && x_seen_q) fire = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_seen_q <= 1'b0;
      y_seen_q <= 1'b0;
    end else if (fire) begin
      x_seen_q <= 1'b0;
      y_seen_q <= 1'b0;
    end else begin
      if (wr_x) x_seen_q <= 1'b1;
      if (wr_y) y_seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mulacc_datapath.sv
module mulacc_datapath
  import mulacc_pkg::*;
(
  input  mode_t              mode,
  input  logic [WORD_W-1:0]  opx_q,
  input  logic [WORD_W-1:0]  opy_q,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               wr_x,
  input  logic               wr_y,
  input  logic [ACC_W-1:0]   acc_q,
  output logic [PROD_W-1:0]  prod_next,
  output logic [ACC_W-1:0]   acc_next,
  output logic               ovf_hit
);

  logic [WORD_W-1:0] fac_x;
  logic [WORD_W-1:0] fac_y;
  acc_step_t         step;

  // the word being written is used directly so the result lands at this edge
  always_comb begin
    if (mode.square) begin
      fac_x = wdata;
      fac_y = wdata;
    end else begin
      fac_x = wr_x ? wdata : opx_q;
      fac_y = wr_y ? wdata : opy_q;
    end
  end

  always_comb begin
    prod_next = mul_raw(fac_x, fac_y, mode.unsig);
    step      = acc_step(acc_q, prod_next, mode);
    acc_next  = step.acc;
    ovf_hit   = step.ovf;
  end

endmodule

// File: rtl/mulacc_readmux.sv
module mulacc_readmux
  import mulacc_pkg::*;
(
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  mode_t              mode_q,
  input  logic               ovf_q,
  input  logic [WORD_W-1:0]  opx_q,
  input  logic [WORD_W-1:0]  opy_q,
  input  logic [ACC_W-1:0]   acc_q,
  input  logic [PROD_W-1:0]  prod_q,
  output logic [WORD_W-1:0]  rdata
);

  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      ADR_CTRL: begin
        sel             = WORD_W'(mode_q);
        sel[CB_OVF]     = ovf_q;
      end
      ADR_OPX:     sel = opx_q;
      ADR_OPY:     sel = opy_q;
      ADR_PROD_HI: sel = prod_q[PROD_W-1:WORD_W];
      ADR_PROD_LO: sel = prod_q[WORD_W-1:0];
      default:     sel = '0;
    endcase
    for (int s = 0; s < NSLICE; s++) begin
      if (addr == slice_addr(s)) sel = acc_q[s*WORD_W +: WORD_W];
    end
  end

  assign rdata = rd_en ? sel : '0;

endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  mode_t              mode_q;
  logic               ovf_q;
  logic [WORD_W-1:0]  opx_q;
  logic [WORD_W-1:0]  opy_q;
  logic [ACC_W-1:0]   acc_q;
  logic [PROD_W-1:0]  prod_q;

  // named events, also watched by the checker
  logic               wr_ctrl;
  logic               wr_x;
  logic               wr_y;
  logic               clear_req;
  logic               op_fire;
  logic [PROD_W-1:0]  prod_next;
  logic [ACC_W-1:0]   acc_next;
  logic               ovf_hit;
  logic [NSLICE-1:0]  wr_slice;

  assign wr_ctrl   = wr_en && (addr == ADR_CTRL);
  assign wr_x      = wr_en && (addr == ADR_OPX);
  assign wr_y      = wr_en && (addr == ADR_OPY);
  assign clear_req = wr_ctrl && wdata[CB_CLEAR];

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice_dec
    assign wr_slice[s] = wr_en && (addr == slice_addr(s));
  end

  mulacc_trigger u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_x   (wr_x),
    .wr_y   (wr_y),
    .square (mode_q.square),
    .fire   (op_fire)
  );

  mulacc_datapath u_dp (
    .mode      (mode_q),
    .opx_q     (opx_q),
    .opy_q     (opy_q),
    .wdata     (wdata),
    .wr_x      (wr_x),
    .wr_y      (wr_y),
    .acc_q     (acc_q),
    .prod_next (prod_next),
    .acc_next  (acc_next),
    .ovf_hit   (ovf_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ovf_q  <= 1'b0;
      opx_q  <= '0;
      opy_q  <= '0;
      acc_q  <= '0;
      prod_q <= '0;
    end else begin
      if (wr_ctrl) mode_q <= mode_t'(wdata[MODE_W-1:0]);
      if (wr_x)    opx_q  <= wdata;
      if (wr_y)    opy_q  <= wdata;
      if (clear_req) begin
        acc_q <= '0;
        ovf_q <= 1'b0;
      end
      if (op_fire) begin
        prod_q <= prod_next;
        acc_q  <= acc_next;
        if (ovf_hit) ovf_q <= 1'b1;
      end
      for (int s = 0; s < NSLICE; s++) begin
        if (wr_slice[s]) acc_q[s*WORD_W +: WORD_W] <= wdata;
      end
    end
  end

  mulacc_readmux u_rd (
    .rd_en  (rd_en),
    .addr   (addr),
    .mode_q (mode_q),
    .ovf_q  (ovf_q),
    .opx_q  (opx_q),
    .opy_q  (opy_q),
    .acc_q  (acc_q),
    .prod_q (prod_q),
    .rdata  (rdata)
  );

endmodule

// File: rtl/mulacc_checker.sv
module mulacc_checker
  import mulacc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [WORD_W-1:0]  wdata,
  input logic [WORD_W-1:0]  rdata,
  input logic               fire,
  input logic [ACC_W-1:0]   acc_q,
  input logic [PROD_W-1:0]  prod_q,
  input logic               ovf_q
);

  logic clr_wr;
  logic slice_wr;
  logic mapped;

  assign clr_wr   = wr_en && (addr == ADR_CTRL) && wdata[CB_CLEAR];
  assign slice_wr = wr_en && (addr >= 4'd3) && (addr <= 4'd5);
  assign mapped   = (addr <= 4'd5) || (addr == ADR_PROD_HI) || (addr == ADR_PROD_LO);

  a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |-> rdata == '0);

  a_r3_fire_on_operand_write: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (wr_en && (addr == ADR_OPX || addr == ADR_OPY)));

  a_r4_total_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !slice_wr && !clr_wr) |=> $stable(acc_q));

  a_r5_product_holds_without_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(prod_q));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_wr) |=> ovf_q);

  a_r10_clear_zeroes_total: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (acc_q == '0 && !ovf_q));

  a_r11_product_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADR_PROD_HI || addr == ADR_PROD_LO) && !fire) |=> $stable(prod_q));

endmodule

bind mulacc_unit mulacc_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .fire   (op_fire),
  .acc_q  (acc_q),
  .prod_q (prod_q),
  .ovf_q  (ovf_q)
);

// File: tb/mulacc_unit_tb_top.sv
module mulacc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model state
  logic [4:0]  m_mode = '0;
  logic        m_ovf = 1'b0;
  logic [15:0] m_x = '0;
  logic [15:0] m_y = '0;
  logic [47:0] m_acc = '0;
  logic [31:0] m_prod = '0;
  logic        m_xs = 1'b0;
  logic        m_ys = 1'b0;

  always #5 clk = ~clk;

  mulacc_unit dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  function automatic logic [15:0] mdl_read(input logic [3:0] a);
    case (a)
      4'd0: return {8'h00, m_ovf, 2'b00, m_mode};
      4'd1: return m_x;
      4'd2: return m_y;
      4'd3: return m_acc[47:32];
      4'd4: return m_acc[31:16];
      4'd5: return m_acc[15:0];
      4'd8: return m_prod[31:16];
      4'd9: return m_prod[15:0];
      default: return 16'h0000;
    endcase
  endfunction

  // arithmetic restated with 64-bit signed integers
  function automatic longint to_int16(input logic [15:0] v, input logic u);
    return u ? longint'(v) : longint'($signed(v));
  endfunction

  task automatic mdl_operate(input logic [15:0] fx, input logic [15:0] fy);
    longint lim, p, term, base, sum;
    logic u;
    u      = m_mode[0];
    p      = to_int16(fx, u) * to_int16(fy, u);
    m_prod = p[31:0];
    term   = u ? longint'(m_prod) : longint'($signed(m_prod));
    if (m_mode[3]) term = -term;
    if (!m_mode[1]) begin
      sum = term;
    end else begin
      base = u ? longint'(m_acc) : longint'($signed(m_acc));
      sum  = m_mode[2] ? base - term : base + term;
      lim  = longint'(1) <<< 47;
      if (u) begin
        if (sum < 0 || sum >= (lim <<< 1)) m_ovf = 1'b1;
      end else begin
        if (sum < -lim || sum >= lim) m_ovf = 1'b1;
      end
    end
    m_acc = sum[47:0];
    m_xs  = 1'b0;
    m_ys  = 1'b0;
  endtask

  task automatic mdl_write(input logic [3:0] a, input logic [15:0] d);
    case (a)
      4'd0: begin
        m_mode = d[4:0];
        if (d[5]) begin m_acc = '0; m_ovf = 1'b0; end
      end
      4'd1: begin
        m_x = d;
        if (m_mode[4])  mdl_operate(d, d);
        else if (m_ys)  mdl_operate(m_x, m_y);
        else            m_xs = 1'b1;
      end
      4'd2: begin
        m_y = d;
        if (m_mode[4])  mdl_operate(d, d);
        else if (m_xs)  mdl_operate(m_x, m_y);
        else            m_ys = 1'b1;
      end
      4'd3: m_acc[47:32] = d;
      4'd4: m_acc[31:16] = d;
      4'd5: m_acc[15:0]  = d;
      default: ;
    endcase
  endtask

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    mdl_write(a, d);
    #1 wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic read_check(input logic [3:0] a, input string tag);
    logic [15:0] v;
    bus_read(a, v);
    check16(tag, v, mdl_read(a));
  endtask

  task automatic read_expect(input logic [3:0] a, input logic [15:0] e, input string tag);
    logic [15:0] v;
    bus_read(a, v);
    check16(tag, v, e);
  endtask

  task automatic total_check(input logic [47:0] e, input string tag);
    read_expect(4'd3, e[47:32], tag);
    read_expect(4'd4, e[31:16], tag);
    read_expect(4'd5, e[15:0], tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state on every address; R1 unmapped reads zero
    for (int a = 0; a < 16; a++) read_expect(4'(a), 16'h0000, "R2 reset read");

    // R1 read strobe low gives zero
    bus_write(4'd1, 16'h1234);
    @(negedge clk); addr = 4'd1; rd_en = 1'b0;
    #1 check16("R1 idle read zero", rdata, 16'h0000);
    read_expect(4'd1, 16'h1234, "R1 operand X readback");
    bus_write(4'd0, 16'h0020);
    bus_write(4'd2, 16'h0001); // completes pair: signed 0x1234*1
    read_expect(4'd5, 16'h1234, "R6 signed load");

    // worked example: unsigned load then square-accumulate
    bus_write(4'd0, 16'h0021);
    read_expect(4'd0, 16'h0001, "R10 clear bit reads zero");
    total_check(48'h0, "R10 clear zeroes total");
    bus_write(4'd1, 16'h0155);
    total_check(48'h0, "R3 lone operand no fire");
    bus_write(4'd1, 16'h0155);
    total_check(48'h0, "R3 repeated operand no fire");
    bus_write(4'd2, 16'h00AA);
    total_check(48'h0000_0000_E272, "R6 unsigned load");
    read_expect(4'd9, 16'hE272, "R5 product low");
    read_expect(4'd8, 16'h0000, "R5 product high");
    bus_write(4'd0, 16'h0012);
    bus_write(4'd1, 16'h00FF);
    total_check(48'h0000_0001_E073, "R8 square via X");
    bus_write(4'd2, 16'h0099);
    total_check(48'h0000_0002_3BE4, "R8 square via Y");

    // signed product, sign extension
    bus_write(4'd0, 16'h0020);
    bus_write(4'd1, 16'hFFFF);
    bus_write(4'd2, 16'h0003);
    total_check(48'hFFFF_FFFF_FFFD, "R6 signed sign extension");
    read_expect(4'd8, 16'hFFFF, "R5 signed raw product");
    // unsigned same operands
    bus_write(4'd0, 16'h0001);
    bus_write(4'd2, 16'h0003);
    bus_write(4'd1, 16'hFFFF);
    total_check(48'h0000_0002_FFFD, "R5 unsigned product");

    // negate, then subtract-accumulate
    bus_write(4'd0, 16'h0008);
    bus_write(4'd1, 16'h0002);
    bus_write(4'd2, 16'h0003);
    total_check(48'hFFFF_FFFF_FFFA, "R6 negate");
    read_expect(4'd9, 16'h0006, "R5 raw product ignores negate");
    bus_write(4'd0, 16'h0006);
    bus_write(4'd1, 16'h0001);
    bus_write(4'd2, 16'h0001);
    total_check(48'hFFFF_FFFF_FFF9, "R7 signed subtract");
    bus_write(4'd0, 16'h0002);
    bus_write(4'd1, 16'h0004);
    bus_write(4'd2, 16'h0002);
    total_check(48'h0000_0000_0001, "R7 signed accumulate");
    read_expect(4'd0, 16'h0002, "R9 no false overflow");

    // unsigned overflow by wrap
    bus_write(4'd3, 16'hFFFF);
    bus_write(4'd4, 16'hFFFF);
    bus_write(4'd5, 16'hFFFF);
    total_check(48'hFFFF_FFFF_FFFF, "R11 total slices writable");
    bus_write(4'd0, 16'h0003);
    bus_write(4'd1, 16'h0001);
    bus_write(4'd2, 16'h0001);
    total_check(48'h0, "R7 wrap modulo 2^48");
    read_expect(4'd0, 16'h0083, "R9 unsigned overflow set");
    bus_write(4'd0, 16'h0083);
    bus_write(4'd2, 16'h0002);
    bus_write(4'd1, 16'h0002);
    read_expect(4'd0, 16'h0083, "R9 overflow sticky");
    read_expect(4'd5, 16'h0004, "R9 total after sticky");
    // clear and mode change in one write
    bus_write(4'd0, 16'h0023);
    read_expect(4'd0, 16'h0003, "R10 clear drops overflow");
    bus_write(4'd1, 16'h0003);
    bus_write(4'd2, 16'h0003);
    total_check(48'h0000_0000_0009, "R10 new mode from zero");

    // signed overflow
    bus_write(4'd3, 16'h7FFF);
    bus_write(4'd4, 16'hFFFF);
    bus_write(4'd5, 16'hFFFF);
    bus_write(4'd0, 16'h0002);
    bus_write(4'd1, 16'h0001);
    bus_write(4'd2, 16'h0001);
    total_check(48'h8000_0000_0000, "R7 signed wrap");
    read_expect(4'd0, 16'h0082, "R9 signed overflow set");

    // writes that must be ignored
    read_check(4'd8, "R11 product before ignored write");
    bus_write(4'd8, 16'hABCD);
    bus_write(4'd9, 16'h5555);
    bus_write(4'd12, 16'h7777);
    read_check(4'd8, "R11 product high unchanged");
    read_check(4'd9, "R11 product low unchanged");
    read_expect(4'd12, 16'h0000, "R1 unmapped read zero");

    // read and write on the same cycle of a firing write
    bus_write(4'd0, 16'h0021);
    bus_write(4'd1, 16'h0005);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 4'd2; wdata = 16'h0007;
    #1 check16("R4 read during write sees old", rdata, mdl_read(4'd2));
    @(posedge clk);
    mdl_write(4'd2, 16'h0007);
    #1 begin wr_en = 1'b0; rd_en = 1'b0; end
    total_check(48'h0000_0000_0023, "R4 result next cycle");

    // constrained random mix against the model
    for (int i = 0; i < 800; i++) begin
      int kind;
      logic [3:0]  a;
      logic [15:0] d;
      kind = int'($urandom_range(0, 11));
      d    = 16'($urandom);
      case (kind)
        0: begin a = 4'd0; d = {10'd0, ($urandom_range(0, 7) == 0), d[4:0]}; end
        1, 2, 3: a = 4'd1;
        4, 5, 6: a = 4'd2;
        7: a = 4'(3 + $urandom_range(0, 2));
        8: a = 4'(8 + $urandom_range(0, 1));
        9: a = 4'(10 + $urandom_range(0, 5));
        default: a = 4'(1 + $urandom_range(0, 1));
      endcase
      bus_write(a, d);
      read_check(4'($urandom_range(0, 15)), "R7 random readback");
      if (i % 50 == 0) begin
        for (int r = 0; r < 10; r++) read_check(4'(r), "R5 random sweep");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule